// File: doc/BRIEF.md
# Acquisition Scan Sequencer

This block decides which analog-input channel each conversion samples. A single configuration word written over a simple write bus sets the uppermost channel of the scan, a gain code, the input polarity, the pacing source and the acquisition mode. When scanning is armed, each pacing event issues a conversion on the current channel and moves the channel counter one step down. Below channel 0 it wraps to the uppermost channel, so the channels repeat in a fixed descending loop.

Scanning is armed only by a fixed two-write handshake. First the configuration is written with the scan bit clear, which also loads the channel counter. Then the same configuration is written again with the scan bit set. While scanning is not armed, conversions still happen, but the counter holds its value.

Pacing comes from one of two sources: a one-cycle pulse from an internal interval counter, or an active-low asynchronous convert strobe. Incoming samples are stored in a 16-entry FIFO, each one tagged with the channel of the latest conversion. The FIFO raises a data-available flag. When the interrupt is enabled, that flag drives a conversion-complete interrupt, which stays asserted until the FIFO has been read empty.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `conv_start`, `conv_chan`, `gain_code`, `bipolar`, `data_avail` and `irq` are all 0.
- R2: When scanning is armed, successive conversions report the channels top, top-1, ... 0, then top again, and the order repeats. Pacing pulses on back-to-back cycles each advance one step.
- R3: Scanning is armed only when an address-0 write with bit 9 = 1 directly follows an address-0 write with bit 9 = 0 carrying identical bits [8:0]. Two cases leave scanning off and the channel counter holding the value that the bit-9 = 0 write loaded: a set-bit write with different contents, and a set-bit write with no preceding clear-bit write.
- R4: Each accepted pacing event produces exactly one cycle of `conv_start`, and `conv_chan` gives the channel of that conversion.
- R5: Config bit 7 selects the pacing source: 0 means `int_pace` pulses, 1 means falling edges of `ext_conv_n`. The source that is not selected has no effect.
- R6: `ext_conv_n` is synchronized and edge-detected, so one low pulse of any length yields exactly one conversion.
- R7: Config bit 8 = 1 selects free-running mode, in which `acq_gate` is ignored. Bit 8 = 0 selects controlled mode, in which pacing events are accepted only while `acq_gate` is high.
- R8: Each `smp_valid` cycle stores `{conv_chan, smp_data}` into the FIFO. The channel sits in bits [14:12] and the sample in bits [11:0]. A `fifo_rd` pulse presents the oldest entry on `fifo_dout` one cycle later.
- R9: `data_avail` is high exactly when the FIFO is not empty. The FIFO holds 16 entries, and a store into a full FIFO is dropped.
- R10: With the interrupt enable set (address 1, bit 0), `irq` rises while `data_avail` is high. It falls only after the FIFO has been emptied, or after the enable is cleared.
- R11: `gain_code` reflects config bits [5:3] and `bipolar` reflects config bit 6. The top channel is config bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = configuration, 1 = interrupt enable |
| bus_wdata | input | 16 | Write data |
| int_pace | input | 1 | Internal interval counter pulse |
| ext_conv_n | input | 1 | Asynchronous active-low external convert strobe |
| acq_gate | input | 1 | Acquisition gate for controlled mode |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 3 | Channel of the current conversion |
| gain_code | output | 3 | Configured gain code |
| bipolar | output | 1 | Configured input polarity |
| smp_valid | input | 1 | Sample strobe from the converter |
| smp_data | input | 12 | Converted sample |
| fifo_rd | input | 1 | FIFO read strobe |
| fifo_dout | output | 15 | Channel and sample read from the FIFO |
| data_avail | output | 1 | FIFO not empty |
| irq | output | 1 | Conversion-complete interrupt |

## Verification
The channel stepping is driven with several kinds of pacing: spaced internal pulses, back-to-back internal pulses, short and long external low pulses, and pulses while the gate is closed. This separates a correct descending wrap from counters that skip, double-step or step on level rather than edge. Three write patterns are tried: matching pairs, a pair with mismatched contents, and a lone set-bit write. Only the correct handshake should make the channel move. The FIFO is filled past its depth and drained, to tell drop-on-full apart from overwrite, and to show that the interrupt follows emptiness and not individual reads.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic {PACE_INT = 1'b0, PACE_EXT = 1'b1} pace_src_e;
  localparam logic ADDR_CFG = 1'b0;
  localparam logic ADDR_IRQ = 1'b1;
endpackage

// File: rtl/scan_cfg.sv
module scan_cfg
  import scan_pkg::*;
#(
  parameter int CH_W   = 3,
  parameter int GAIN_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [CH_W-1:0]   top_ch,
  output logic [GAIN_W-1:0] gain,
  output logic              bipolar,
  output pace_src_e         pace_src,
  output logic              freerun,
  output logic              scan_on,
  output logic              cnt_load,
  output logic              irq_en
);
  localparam int POS_GAIN = CH_W;
  localparam int POS_BIP  = CH_W + GAIN_W;
  localparam int POS_EXT  = POS_BIP + 1;
  localparam int POS_FREE = POS_EXT + 1;
  localparam int POS_EN   = POS_FREE + 1;
  localparam int FLD_W    = POS_EN;

  logic [FLD_W-1:0] fields;
  logic [FLD_W-1:0] shadow;
  logic             pending;
  logic             cfg_wr;
  logic             irq_wr;
  logic             en_bit;
  logic [FLD_W-1:0] fld_in;

  assign cfg_wr = bus_wr && (bus_addr == ADDR_CFG);
  assign irq_wr = bus_wr && (bus_addr == ADDR_IRQ);
  assign en_bit = bus_wdata[POS_EN];
  assign fld_in = bus_wdata[FLD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      fields   <= '0;
      shadow   <= '0;
      pending  <= 1'b0;
      scan_on  <= 1'b0;
      cnt_load <= 1'b0;
      irq_en   <= 1'b0;
    end else begin
      cnt_load <= cfg_wr && !en_bit;
      if (cfg_wr) begin
        fields <= fld_in;
        if (!en_bit) begin
          shadow  <= fld_in;
          pending <= 1'b1;
          scan_on <= 1'b0;
        end else begin
          scan_on <= pending && (fld_in == shadow);
          pending <= 1'b0;
        end
      end
      if (irq_wr) irq_en <= bus_wdata[0];
    end
  end

  assign top_ch   = fields[CH_W-1:0];
  assign gain     = fields[POS_BIP-1:POS_GAIN];
  assign bipolar  = fields[POS_BIP];
  assign pace_src = pace_src_e'(fields[POS_EXT]);
  assign freerun  = fields[POS_FREE];
endmodule

// File: rtl/pace_sync.sv
module pace_sync
  import scan_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      int_pace,
  input  logic      ext_conv_n,
  input  pace_src_e pace_src,
  input  logic      freerun,
  input  logic      acq_gate,
  output logic      ext_fall,
  output logic      pace_evt
);
  logic sync1, sync2, sync_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1     <= 1'b1;
      sync2     <= 1'b1;
      sync_prev <= 1'b1;
    end else begin
      sync1     <= ext_conv_n;
      sync2     <= sync1;
      sync_prev <= sync2;
    end
  end

  assign ext_fall = sync_prev && !sync2;

  always_comb begin
    pace_evt = (pace_src == PACE_EXT) ? ext_fall : int_pace;
    pace_evt = pace_evt && (freerun || acq_gate);
  end
endmodule

// File: rtl/chan_stepper.sv
module chan_stepper #(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [CH_W-1:0] top_ch,
  input  logic            step,
  input  logic            scan_on,
  output logic [CH_W-1:0] cnt,
  output logic            conv_start,
  output logic [CH_W-1:0] conv_chan
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
    end else begin
      conv_start <= step;
      if (step) conv_chan <= cnt;
      if (load) begin
        cnt <= top_ch;
      end else if (step && scan_on) begin
        cnt <= (cnt == '0) ? top_ch : cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int W     = 15,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push_ok, pop_ok;

  assign push_ok = push && (count != CW'(DEPTH));
  assign pop_ok  = pop && (count != '0);
  assign empty   = (count == '0);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      dout  <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok) begin
        rptr <= rptr + 1'b1;
        dout <= mem[rptr];
      end
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import scan_pkg::*;
#(
  parameter int CH_W       = 3,
  parameter int GAIN_W     = 3,
  parameter int DATA_W     = 16,
  parameter int SMP_W      = 12,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic                  int_pace,
  input  logic                  ext_conv_n,
  input  logic                  acq_gate,
  output logic                  conv_start,
  output logic [CH_W-1:0]       conv_chan,
  output logic [GAIN_W-1:0]     gain_code,
  output logic                  bipolar,
  input  logic                  smp_valid,
  input  logic [SMP_W-1:0]      smp_data,
  input  logic                  fifo_rd,
  output logic [CH_W+SMP_W-1:0] fifo_dout,
  output logic                  data_avail,
  output logic                  irq
);
  localparam int ENT_W = CH_W + SMP_W;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [CH_W-1:0]  top_ch;
  logic [CH_W-1:0]  cnt;
  pace_src_e        pace_src;
  logic             freerun, scan_on, cnt_load, irq_en;
  logic             ext_fall, pace_evt;
  logic [CNT_W-1:0] fifo_count;
  logic             fifo_empty;

  scan_cfg #(.CH_W(CH_W), .GAIN_W(GAIN_W), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .top_ch(top_ch), .gain(gain_code),
    .bipolar(bipolar), .pace_src(pace_src), .freerun(freerun),
    .scan_on(scan_on), .cnt_load(cnt_load), .irq_en(irq_en)
  );

  pace_sync u_pace (
    .clk(clk), .rst(rst), .int_pace(int_pace), .ext_conv_n(ext_conv_n),
    .pace_src(pace_src), .freerun(freerun), .acq_gate(acq_gate),
    .ext_fall(ext_fall), .pace_evt(pace_evt)
  );

  chan_stepper #(.CH_W(CH_W)) u_step (
    .clk(clk), .rst(rst), .load(cnt_load), .top_ch(top_ch),
    .step(pace_evt), .scan_on(scan_on), .cnt(cnt),
    .conv_start(conv_start), .conv_chan(conv_chan)
  );

  sample_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(smp_valid), .din({conv_chan, smp_data}),
    .pop(fifo_rd), .dout(fifo_dout), .count(fifo_count), .empty(fifo_empty)
  );

  assign data_avail = !fifo_empty;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_en && !fifo_empty;
  end
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int CH_W  = 3,
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       pace_evt,
  input logic                       scan_on,
  input logic                       cnt_load,
  input logic [CH_W-1:0]            cnt,
  input logic [CH_W-1:0]            top_ch,
  input logic                       ext_fall,
  input logic                       conv_start,
  input logic [$clog2(DEPTH+1)-1:0] fifo_count,
  input logic                       data_avail,
  input logic                       irq
);
  // R2
  step_down_chk: assert property (@(posedge clk) disable iff (rst)
    (pace_evt && scan_on && !cnt_load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R2
  wrap_top_chk: assert property (@(posedge clk) disable iff (rst)
    (pace_evt && scan_on && !cnt_load && cnt == '0) |=> (cnt == $past(top_ch)));

  // R3
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!scan_on && !cnt_load) |=> $stable(cnt));

  // R4
  conv_follow_chk: assert property (@(posedge clk) disable iff (rst)
    pace_evt |=> conv_start);

  // R6
  single_edge_chk: assert property (@(posedge clk) disable iff (rst)
    ext_fall |=> !ext_fall);

  // R9
  no_overfill_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= ($clog2(DEPTH+1))'(DEPTH));

  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !data_avail |=> !irq);
endmodule

bind adc_scan_seq scan_seq_chk #(.CH_W(CH_W), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .pace_evt(pace_evt), .scan_on(scan_on),
  .cnt_load(cnt_load), .cnt(cnt), .top_ch(top_ch), .ext_fall(ext_fall),
  .conv_start(conv_start), .fifo_count(fifo_count),
  .data_avail(data_avail), .irq(irq)
);

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        int_pace = 1'b0;
  logic        ext_conv_n = 1'b1;
  logic        acq_gate = 1'b0;
  logic        conv_start;
  logic [2:0]  conv_chan;
  logic [2:0]  gain_code;
  logic        bipolar;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_data = '0;
  logic        fifo_rd = 1'b0;
  logic [14:0] fifo_dout;
  logic        data_avail;
  logic        irq;

  int errors = 0;
  int checks = 0;
  string cur_req = "R2";
  int unsigned exp_ch[$];
  int unsigned exp_ent[$];

  always #(CLK_NS/2) clk = ~clk;

  adc_scan_seq uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .int_pace(int_pace), .ext_conv_n(ext_conv_n),
    .acq_gate(acq_gate), .conv_start(conv_start), .conv_chan(conv_chan),
    .gain_code(gain_code), .bipolar(bipolar), .smp_valid(smp_valid),
    .smp_data(smp_data), .fifo_rd(fifo_rd), .fifo_dout(fifo_dout),
    .data_avail(data_avail), .irq(irq)
  );

  task automatic check(string req, int unsigned act, int unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: compares each conversion against the scoreboard queue (R4)
  always @(negedge clk) begin
    if (!rst && conv_start) begin
      if (exp_ch.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL %s: actual=unexpected conversion ch %0d expected=none", cur_req, conv_chan);
      end else begin
        check(cur_req, conv_chan, exp_ch.pop_front());
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(logic addr, logic [15:0] data);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  function automatic logic [15:0] cfg(int top, int gain, bit bip, bit ext, bit free, bit en);
    return {6'd0, en, free, ext, bip, gain[2:0], top[2:0]};
  endfunction

  task automatic arm(int top, int gain, bit bip, bit ext, bit free);
    bus_write(1'b0, cfg(top, gain, bip, ext, free, 1'b0));
    bus_write(1'b0, cfg(top, gain, bip, ext, free, 1'b1));
    idle(2);
  endtask

  task automatic pulse_int(int gap);
    @(negedge clk); int_pace = 1'b1;
    @(negedge clk); int_pace = 1'b0;
    idle(gap);
  endtask

  task automatic pulse_ext(int low_cycles);
    @(negedge clk); ext_conv_n = 1'b0;
    idle(low_cycles);
    ext_conv_n = 1'b1;
    idle(5);
  endtask

  task automatic drained(string req);
    idle(6);
    check(req, exp_ch.size(), 0);
  endtask

  task automatic push_sample(int ch, int val);
    exp_ent.push_back((ch << 12) | val);
    @(negedge clk); smp_valid = 1'b1; smp_data = val[11:0];
    @(negedge clk); smp_valid = 1'b0;
  endtask

  task automatic read_check(string req);
    int unsigned e;
    e = exp_ent.pop_front();
    @(negedge clk); fifo_rd = 1'b1;
    @(negedge clk); fifo_rd = 1'b0;
    check(req, fifo_dout, e);
  endtask

  initial begin
    #(CLK_NS * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check("R1", conv_start, 0);
    check("R1", conv_chan, 0);
    check("R1", gain_code, 0);
    check("R1", bipolar, 0);
    check("R1", data_avail, 0);
    check("R1", irq, 0);

    // R2 descending scan with wrap, spaced and back-to-back pulses
    cur_req = "R2";
    arm(3, 2, 1'b1, 1'b0, 1'b1);
    check("R11", gain_code, 2);
    check("R11", bipolar, 1);
    foreach (exp_ch[i]) begin end
    exp_ch.push_back(3); exp_ch.push_back(2); exp_ch.push_back(1);
    exp_ch.push_back(0); exp_ch.push_back(3); exp_ch.push_back(2);
    exp_ch.push_back(1);
    for (int i = 0; i < 7; i++) pulse_int(3);
    exp_ch.push_back(0); exp_ch.push_back(3);
    @(negedge clk); int_pace = 1'b1;
    idle(2); int_pace = 1'b0;
    drained("R2");

    // R3 mismatched second write and lone set-bit write leave scan off
    cur_req = "R3";
    bus_write(1'b0, cfg(2, 1, 1'b0, 1'b0, 1'b1, 1'b0));
    bus_write(1'b0, cfg(5, 1, 1'b0, 1'b0, 1'b1, 1'b1));
    idle(2);
    for (int i = 0; i < 3; i++) begin exp_ch.push_back(2); pulse_int(3); end
    bus_write(1'b0, cfg(2, 1, 1'b0, 1'b0, 1'b1, 1'b1));
    idle(2);
    for (int i = 0; i < 2; i++) begin exp_ch.push_back(2); pulse_int(3); end
    drained("R3");
    arm(2, 1, 1'b0, 1'b0, 1'b1);
    exp_ch.push_back(2); exp_ch.push_back(1); exp_ch.push_back(0); exp_ch.push_back(2);
    for (int i = 0; i < 4; i++) pulse_int(3);
    drained("R3");

    // R5 external source selected: internal pulses ignored
    cur_req = "R5";
    arm(1, 0, 1'b0, 1'b1, 1'b1);
    exp_ch.push_back(1); exp_ch.push_back(0); exp_ch.push_back(1);
    for (int i = 0; i < 3; i++) pulse_ext(2);
    for (int i = 0; i < 3; i++) pulse_int(3);
    drained("R5");
    // internal source selected: external pulses ignored
    arm(1, 0, 1'b0, 1'b0, 1'b1);
    pulse_ext(2);
    pulse_ext(3);
    drained("R5");
    exp_ch.push_back(1);
    pulse_int(3);
    drained("R5");

    // R6 long low pulse gives a single conversion
    cur_req = "R6";
    arm(3, 0, 1'b0, 1'b1, 1'b1);
    exp_ch.push_back(3);
    pulse_ext(25);
    drained("R6");
    exp_ch.push_back(2);
    pulse_ext(1);
    drained("R6");

    // R7 controlled mode gated by acq_gate; free-run ignores it
    cur_req = "R7";
    arm(2, 0, 1'b0, 1'b0, 1'b0);
    acq_gate = 1'b0;
    pulse_int(3); pulse_int(3);
    drained("R7");
    acq_gate = 1'b1;
    exp_ch.push_back(2); exp_ch.push_back(1);
    pulse_int(3); pulse_int(3);
    drained("R7");
    acq_gate = 1'b0;
    arm(2, 5, 1'b1, 1'b0, 1'b1);
    check("R11", gain_code, 5);
    exp_ch.push_back(2);
    pulse_int(3);
    drained("R7");

    // R8 FIFO entries tagged with the latest conversion channel
    cur_req = "R8";
    push_sample(2, 12'h123);
    push_sample(2, 12'hABC);
    push_sample(2, 12'h7FF);
    exp_ch.push_back(1);
    pulse_int(3);
    push_sample(1, 12'h001);
    idle(1);
    check("R9", data_avail, 1);
    check("R10", irq, 0);
    for (int i = 0; i < 4; i++) read_check("R8");
    idle(1);
    check("R9", data_avail, 0);

    // R9 fill past depth: only 16 entries kept
    for (int i = 0; i < 18; i++) push_sample(1, 100 + i);
    exp_ent.pop_back();
    exp_ent.pop_back();
    // R10 interrupt enable
    bus_write(1'b1, 16'h0001);
    idle(2);
    check("R10", irq, 1);
    for (int i = 0; i < 15; i++) read_check("R9");
    idle(2);
    check("R10", irq, 1);
    read_check("R9");
    idle(2);
    check("R9", data_avail, 0);
    check("R10", irq, 0);
    // R10 clearing the enable drops irq with data present
    push_sample(1, 12'h555);
    idle(2);
    check("R10", irq, 1);
    bus_write(1'b1, 16'h0000);
    idle(2);
    check("R10", irq, 0);
    read_check("R8");
    drained("R4");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule